// File: doc/BRIEF.md
# Discharge Overcurrent Guard

This block watches a battery pack for excessive discharge current through three independent channels. Two channels compare an unsigned sense-resistor differential code against their own threshold codes. The third compares a signed current sample from a coulomb-counter path against a signed current limit. Each channel works in three stages. It raises an alert when its condition first appears. It trips when the condition has held for a programmed number of time-base ticks. After tripping it stays latched until a shared recovery path clears it.

A trip emits a one-cycle event pulse, which a repeated-fault counter elsewhere can use. A trip also requests that the discharge switch be opened, but only for channels whose autonomous switch control bit is set. Recovery needs charge current at or above a recovery limit, held without a break for a programmed number of slow ticks. The condition that caused the trip simply going away does not recover the channel.

Top module: `ocd_guard`

## Requirements
- R1: Channel 0 (bit 0) sees its condition when `vdiff_code` is strictly greater than `thr_v0`. Channel 1 (bit 1) does the same against `thr_v1`. Codes are in 2 mV units, so a code equal to the threshold is not a condition. The alert bit goes high at the first clock edge at which the condition is present.
- R2: On every cycle with `cur_valid` high, the block registers whether `cur_sample` is below `thr_i`. Samples are two's complement, positive meaning charge, so an equal value is not a condition. That flag is channel 2's (bit 2) condition until the next valid sample, and channel 2's alert rises one edge after the flag is set.
- R3: While a channel is in its alert stage, its alert bit is high and its status bit is low. An alert and a status bit are never high together on the same channel.
- R4: A channel in the alert stage trips at the first edge where its count of ticks seen with the condition present has reached the target. For channels 0 and 1 the target is their delay setting plus 2, counted on `tick_fast`. For channel 2 the target is `dly_i`, counted on `tick_slow`. At that edge the status bit is set and the alert bit is cleared.
- R5: If the condition goes away during the alert stage, the alert and the tick count are cleared at that edge. A later detection starts counting again from zero.
- R6: A channel whose enable bit is low has its alert, status and count cleared at the next edge, and it does not respond to its condition.
- R7: `dsg_off` is high exactly when some channel has both its status bit and its `auto_fet` bit set. It follows those bits in the same cycle.
- R8: `trip` of a channel is high for exactly one cycle, in the first cycle its status bit is high.
- R9: On every valid sample, the block registers whether `cur_sample` is at least `rec_thr`. While any status bit is set and that flag is high, `tick_slow` ticks are counted. The first edge at which the count has reached `rec_time` clears all status bits. If the flag is low, the count returns to zero.
- R10: A tripped channel ignores its condition and keeps its status bit until recovery or disable.
- R11: Synchronous reset clears every alert, status, trip and count, and both registered sample flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdiff_code | input | VW | Sense-resistor differential code, 2 mV units |
| thr_v0 | input | VW | Threshold code, channel 0 |
| thr_v1 | input | VW | Threshold code, channel 1 |
| dly_v0 | input | DW | Delay setting, channel 0 (target = setting + 2 fast ticks) |
| dly_v1 | input | DW | Delay setting, channel 1 (target = setting + 2 fast ticks) |
| cur_sample | input | IW | Signed current sample, positive = charge |
| cur_valid | input | 1 | Sample strobe |
| thr_i | input | IW | Signed discharge limit, channel 2 |
| dly_i | input | DW | Delay for channel 2, in slow ticks |
| rec_thr | input | IW | Signed charge-current recovery limit |
| rec_time | input | RW | Recovery hold time, in slow ticks |
| tick_fast | input | 1 | Time base for channels 0 and 1 |
| tick_slow | input | 1 | Time base for channel 2 and recovery |
| ch_en | input | 3 | Per-channel enable |
| auto_fet | input | 3 | Per-channel autonomous switch-off enable |
| alert | output | 3 | Per-channel alert stage |
| status | output | 3 | Per-channel tripped state |
| trip | output | 3 | One-cycle trip event per channel |
| dsg_off | output | 1 | Discharge switch off request |

## Verification
Alerts, trips and status changes appear one edge after the inputs that cause them. Channel 2's alert comes one edge later than that, because its sample is registered first. `dsg_off` follows status and `auto_fet` in the same cycle. The bench drives inputs 2 ns after a rising edge and samples at the falling edge. A behavioural model advances on each rising edge and is compared on every cycle. The directed checks wait at least two falling edges after each change, or longer than the whole delay in ticks, before reading a result.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

    localparam int NCH  = 3;
    localparam int CH_I = 2;
    localparam int VOLT_DLY_OFFSET = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WATCH   = 2'd1,
        ST_TRIPPED = 2'd2
    } ch_state_e;

    function automatic int unsigned dly_offset(input int unsigned ch);
        return (ch == CH_I) ? 0 : VOLT_DLY_OFFSET;
    endfunction

endpackage

// File: rtl/ocd_persist.sv
module ocd_persist
    import ocd_pkg::*;
#(
    parameter int DW     = 8,
    parameter int OFFSET = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cond,
    input  logic          tick,
    input  logic [DW-1:0] dly,
    input  logic          recover,
    output logic          alert,
    output logic          status,
    output logic          trip
);
    localparam int CW = DW + 1;

    ch_state_e     st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    assign target = {1'b0, dly} + CW'(OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            trip <= 1'b0;
        end else begin
            trip <= 1'b0;
            if (!en) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (cond) begin
                            st  <= ST_WATCH;
                            cnt <= '0;
                        end
                    end
                    ST_WATCH: begin
                        if (!cond) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else if (cnt >= target) begin
                            st   <= ST_TRIPPED;
                            trip <= 1'b1;
                            cnt  <= '0;
                        end else if (tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_TRIPPED: begin
                        if (recover) st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign alert  = (st == ST_WATCH);
    assign status = (st == ST_TRIPPED);

endmodule

// File: rtl/ocd_recover.sv
module ocd_recover #(
    parameter int IW = 16,
    parameter int RW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [IW-1:0] sample,
    input  logic                 valid,
    input  logic signed [IW-1:0] thr,
    input  logic [RW-1:0]        rtime,
    input  logic                 tick,
    input  logic                 any_tripped,
    output logic                 recover
);
    logic          chg_ok;
    logic [RW-1:0] rcnt;

    assign recover = any_tripped && chg_ok && (rcnt >= rtime);

    always_ff @(posedge clk) begin
        if (rst) begin
            chg_ok <= 1'b0;
            rcnt   <= '0;
        end else begin
            if (valid) chg_ok <= (sample >= thr);
            if (!any_tripped || !chg_ok || recover) rcnt <= '0;
            else if (tick)                          rcnt <= rcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ocd_guard.sv
module ocd_guard
    import ocd_pkg::*;
#(
    parameter int VW = 8,
    parameter int IW = 16,
    parameter int DW = 8,
    parameter int RW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VW-1:0]        vdiff_code,
    input  logic [VW-1:0]        thr_v0,
    input  logic [VW-1:0]        thr_v1,
    input  logic [DW-1:0]        dly_v0,
    input  logic [DW-1:0]        dly_v1,
    input  logic signed [IW-1:0] cur_sample,
    input  logic                 cur_valid,
    input  logic signed [IW-1:0] thr_i,
    input  logic [DW-1:0]        dly_i,
    input  logic signed [IW-1:0] rec_thr,
    input  logic [RW-1:0]        rec_time,
    input  logic                 tick_fast,
    input  logic                 tick_slow,
    input  logic [2:0]           ch_en,
    input  logic [2:0]           auto_fet,
    output logic [2:0]           alert,
    output logic [2:0]           status,
    output logic [2:0]           trip,
    output logic                 dsg_off
);
    logic           cur_low;
    logic           recover;
    logic [NCH-1:0] cond;
    logic [NCH-1:0] tick_v;
    logic [DW-1:0]  dly_v [NCH];

    always_ff @(posedge clk) begin
        if (rst)            cur_low <= 1'b0;
        else if (cur_valid) cur_low <= (cur_sample < thr_i);
    end

    assign cond     = {cur_low, (vdiff_code > thr_v1), (vdiff_code > thr_v0)};
    assign tick_v   = {tick_slow, tick_fast, tick_fast};
    assign dly_v[0] = dly_v0;
    assign dly_v[1] = dly_v1;
    assign dly_v[2] = dly_i;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ocd_persist #(
            .DW     (DW),
            .OFFSET (int'(dly_offset(g)))
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .en      (ch_en[g]),
            .cond    (cond[g]),
            .tick    (tick_v[g]),
            .dly     (dly_v[g]),
            .recover (recover),
            .alert   (alert[g]),
            .status  (status[g]),
            .trip    (trip[g])
        );
    end

    ocd_recover #(.IW(IW), .RW(RW)) u_rec (
        .clk         (clk),
        .rst         (rst),
        .sample      (cur_sample),
        .valid       (cur_valid),
        .thr         (rec_thr),
        .rtime       (rec_time),
        .tick        (tick_slow),
        .any_tripped (|status),
        .recover     (recover)
    );

    assign dsg_off = |(status & auto_fet);

endmodule

// File: rtl/ocd_guard_chk.sv
module ocd_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] ch_en,
    input logic [2:0] alert,
    input logic [2:0] status,
    input logic [2:0] trip,
    input logic       dsg_off
);
    // R3
    alert_status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (alert & status) == 3'b000);

    // R8
    trip_single_chk: assert property (@(posedge clk) disable iff (rst)
        (trip != 3'b000) |=> ((trip & $past(trip)) == 3'b000));

    // R8
    trip_with_status_chk: assert property (@(posedge clk) disable iff (rst)
        (trip & ~status) == 3'b000);

    // R4
    trip_drops_alert_chk: assert property (@(posedge clk) disable iff (rst)
        (trip != 3'b000) |-> ((trip & alert) == 3'b000));

    // R6
    disabled_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_en != 3'b111) |=> (((alert | status) & ~$past(ch_en)) == 3'b000));

    // R7
    no_status_no_off_chk: assert property (@(posedge clk) disable iff (rst)
        (status == 3'b000) |-> !dsg_off);
endmodule

bind ocd_guard ocd_guard_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ch_en   (ch_en),
    .alert   (alert),
    .status  (status),
    .trip    (trip),
    .dsg_off (dsg_off)
);

// File: tb/ocd_guard_test.sv
module ocd_guard_test;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic [7:0]         vdiff_code, thr_v0, thr_v1, dly_v0, dly_v1, dly_i, rec_time;
    logic signed [15:0] cur_sample, thr_i, rec_thr;
    logic               cur_valid, tick_fast, tick_slow;
    logic [2:0]         ch_en, auto_fet;
    logic [2:0]         alert, status, trip;
    logic               dsg_off;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocd_guard uut (
        .clk(clk), .rst(rst), .vdiff_code(vdiff_code), .thr_v0(thr_v0), .thr_v1(thr_v1),
        .dly_v0(dly_v0), .dly_v1(dly_v1), .cur_sample(cur_sample), .cur_valid(cur_valid),
        .thr_i(thr_i), .dly_i(dly_i), .rec_thr(rec_thr), .rec_time(rec_time),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .ch_en(ch_en), .auto_fet(auto_fet),
        .alert(alert), .status(status), .trip(trip), .dsg_off(dsg_off)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // time bases: fast every 3 cycles, slow every 5 cycles, driven after the edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        tick_fast <= (cyc % 3) == 0;
        tick_slow <= (cyc % 5) == 0;
    end

    // behavioural reference model: 0 idle, 1 alert, 2 tripped
    int  ms[3];
    int  mc[3];
    bit  mp[3];
    bit  mlow, mchg;
    int  mrcnt;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) begin ms[k] = 0; mc[k] = 0; mp[k] = 0; end
            mlow = 0; mchg = 0; mrcnt = 0;
        end else begin
            bit anyt, rec;
            bit cnd[3];
            int tgt[3];
            bit tk[3];
            anyt = (ms[0] == 2) || (ms[1] == 2) || (ms[2] == 2);
            rec  = anyt && mchg && (mrcnt >= int'(rec_time));
            cnd[0] = vdiff_code > thr_v0;
            cnd[1] = vdiff_code > thr_v1;
            cnd[2] = mlow;
            tgt[0] = int'(dly_v0) + 2;
            tgt[1] = int'(dly_v1) + 2;
            tgt[2] = int'(dly_i);
            tk[0] = tick_fast; tk[1] = tick_fast; tk[2] = tick_slow;
            for (int k = 0; k < 3; k++) begin
                mp[k] = 0;
                if (!ch_en[k]) begin ms[k] = 0; mc[k] = 0; end
                else if (ms[k] == 0) begin
                    if (cnd[k]) begin ms[k] = 1; mc[k] = 0; end
                end else if (ms[k] == 1) begin
                    if (!cnd[k])            begin ms[k] = 0; mc[k] = 0; end
                    else if (mc[k] >= tgt[k]) begin ms[k] = 2; mp[k] = 1; mc[k] = 0; end
                    else if (tk[k])          mc[k]++;
                end else if (rec) ms[k] = 0;
            end
            if (!anyt || !mchg || rec) mrcnt = 0;
            else if (tick_slow)        mrcnt++;
            if (cur_valid) begin
                mlow = cur_sample < thr_i;
                mchg = cur_sample >= rec_thr;
            end
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < 3; k++) begin
                chk($sformatf("R3 alert ch%0d", k), alert[k], ms[k] == 1);
                chk($sformatf("R4 status ch%0d", k), status[k], ms[k] == 2);
                chk($sformatf("R8 trip ch%0d", k), trip[k], mp[k]);
            end
            chk("R7 dsg_off", dsg_off,
                ((ms[0] == 2) && auto_fet[0]) || ((ms[1] == 2) && auto_fet[1]) ||
                ((ms[2] == 2) && auto_fet[2]));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic give_sample(input int v);
        @(posedge clk); #2;
        cur_sample = 16'(v); cur_valid = 1'b1;
        @(posedge clk); #2;
        cur_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; vdiff_code = 0; thr_v0 = 10; thr_v1 = 20; dly_v0 = 1; dly_v1 = 0;
        dly_i = 2; rec_time = 2; cur_sample = 0; thr_i = -100; rec_thr = 20;
        cur_valid = 0; tick_fast = 0; tick_slow = 0; ch_en = 3'b111; auto_fet = 3'b101;
        wait_cyc(3);
        rst = 1'b0;
        settle();
        // R11 reset state
        chk("R11 alert", alert, 0);
        chk("R11 status", status, 0);
        chk("R11 dsg_off", dsg_off, 0);
        // R1 equal code is no condition
        wait_cyc(1); vdiff_code = 10;
        wait_cyc(20);
        chk("R1 equal no alert", alert[0], 0);
        // R1 above threshold: alert after one edge
        vdiff_code = 11;
        settle();
        chk("R1 alert ch0", alert[0], 1);
        wait_cyc(30);
        chk("R4 status ch0", status[0], 1);
        chk("R4 alert cleared", alert[0], 0);
        chk("R7 dsg_off auto", dsg_off, 1);
        // R10 condition gone, still tripped
        vdiff_code = 0;
        wait_cyc(20);
        chk("R10 held", status[0], 1);
        // R9 recovery
        give_sample(50);
        wait_cyc(40);
        chk("R9 recovered", status, 0);
        chk("R9 dsg_off cleared", dsg_off, 0);
        // R5 drop during delay
        give_sample(0);
        vdiff_code = 11;
        wait_cyc(2);
        vdiff_code = 0;
        settle();
        chk("R5 alert cleared", alert[0], 0);
        chk("R5 no trip", status[0], 0);
        // R7 auto off: channels 0 and 1 trip, no switch request
        auto_fet = 3'b100;
        vdiff_code = 25;
        wait_cyc(40);
        chk("R4 status ch1", status[1:0], 3);
        chk("R7 no auto", dsg_off, 0);
        // R6 disable clears
        ch_en = 3'b110; vdiff_code = 0;
        settle();
        chk("R6 disabled ch0", status[0], 0);
        wait_cyc(1); ch_en = 3'b111;
        // R2 current channel
        give_sample(-101);
        wait_cyc(40);
        chk("R2 status ch2", status[2], 1);
        chk("R7 dsg_off ch2", dsg_off, 1);
        // R9 interrupted recovery
        rec_time = 5;
        give_sample(50);
        wait_cyc(8);
        give_sample(0);
        wait_cyc(30);
        chk("R9 interrupted", status[2:1], 3);
        give_sample(50);
        wait_cyc(60);
        chk("R9 full recovery", status, 0);
        // R2 equal sample is no condition
        give_sample(-100);
        wait_cyc(30);
        chk("R2 equal no trip", status[2], 0);
        chk("R2 equal no alert", alert[2], 0);
        wait_cyc(5);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule